// File: doc/BRIEF.md
# Incremental Current Duty Regulator

This block closes the inner current loop of a two-phases-on brushless motor drive. Once per PWM carrier period it takes a fresh 10-bit code from the shunt current converter, compares it with a signed current reference and nudges the stored PWM compare value by the scaled difference. The stored value is then clamped to the carrier range and presented to the PWM generator for the next period. With a 20 kHz carrier, the loop runs every 50 µs. A full-scale code of 0x3FF stands for 30 A and code 0 for no current.

The compare sense is inverted: a larger compare value gives the phase pair less on-time and therefore less current. The error is therefore taken as measured minus reference, so that too much current pushes the compare up. The gain is a power of two chosen by a small signed exponent. The default exponent of 0 gives unity gain. Out of reset the compare sits at the carrier period, which is the weakest drive.

Top module: `cur_duty_reg`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted sample, `duty_cmp` equals PERIOD (default 500).
- R2: The error is `smp_code - iref`. `smp_code` is read as unsigned and `iref` as two's complement (12 bits by default), both in converter codes.
- R3: The step added to the compare is the error times 2^g, where g is `gain_exp`, a 3-bit two's-complement value in the range -4..+3. A negative g is an arithmetic right shift, which rounds toward minus infinity.
- R4: When old compare plus step is at or below zero, the new compare is 0.
- R5: When old compare plus step is at or above PERIOD, the new compare is PERIOD.
- R6: A compare update happens at the rising clock edge where `smp_vld` is high and is visible from that edge on. The compare holds at every edge where `smp_vld` is low.
- R7: The arithmetic never wraps. With the largest positive error and g=+3 the result saturates at PERIOD, and with the largest negative error and g=+3 it saturates at 0.
- R8: Changes on `smp_code`, `iref` or `gain_exp` while `smp_vld` is low leave `duty_cmp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe: a new current sample is present |
| smp_code | input | SAMPLE_W (10) | Unsigned shunt current code |
| iref | input | REF_W (12) | Signed current reference in converter codes |
| gain_exp | input | 3 | Signed power-of-two gain exponent, -4..+3 |
| duty_cmp | output | CMP_W (9) | PWM compare value, 0..PERIOD |

## Verification
Every gain exponent is swept against a dense walk of sample codes, each paired with a reference that varies. Running the compare as a feedback chain separates left shifts from right shifts and shows whether negative errors are floored. It also checks that the previous compare is really the base of each step. Directed steps land the sum exactly on 0 and exactly on PERIOD, and push it just past both bounds, which tells the two clamps apart from an off-by-one. The extreme reference and sample pairings at the top gain expose any wrap in the adder. Idle cycles with changing inputs separate a held compare from one that follows the inputs.

// File: rtl/cur_reg_pkg.sv
package cur_reg_pkg;
  localparam int GAIN_W = 3;
  typedef logic signed [GAIN_W-1:0] gain_t;
  localparam int GAIN_MAX_LSH = (1 << (GAIN_W - 1)) - 1;
endpackage

// File: rtl/cur_err_scale.sv
module cur_err_scale
  import cur_reg_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int REF_W    = 12,
  parameter int SCL_W    = 16
) (
  input  logic [SAMPLE_W-1:0]       smp_code,
  input  logic signed [REF_W-1:0]   iref,
  input  gain_t                     gain_exp,
  output logic signed [SCL_W-1:0]   err_scaled
);
  localparam int ERR_W = ((SAMPLE_W + 1) > REF_W ? (SAMPLE_W + 1) : REF_W) + 1;

  function automatic logic signed [ERR_W-1:0] form_error(
    input logic [SAMPLE_W-1:0] s, input logic signed [REF_W-1:0] r);
    logic signed [ERR_W-1:0] se, re;
    se = ERR_W'(signed'({1'b0, s}));
    re = ERR_W'(r);
    return se - re;
  endfunction

  function automatic logic signed [SCL_W-1:0] pow2_scale(
    input logic signed [ERR_W-1:0] e, input gain_t g);
    logic signed [SCL_W-1:0] ex;
    logic [GAIN_W-1:0] amt;
    ex = SCL_W'(e);
    if (g >= 0) begin
      amt = $unsigned(g);
      return ex <<< amt;
    end
    amt = $unsigned(-g);
    return ex >>> amt;
  endfunction

  logic signed [ERR_W-1:0] err_raw;
  assign err_raw    = form_error(smp_code, iref);
  assign err_scaled = pow2_scale(err_raw, gain_exp);
endmodule

// File: rtl/cur_duty_clamp.sv
module cur_duty_clamp #(
  parameter int PERIOD = 500,
  parameter int CMP_W  = 9,
  parameter int SCL_W  = 16
) (
  input  logic [CMP_W-1:0]         duty_old,
  input  logic signed [SCL_W-1:0]  err_scaled,
  output logic [CMP_W-1:0]         duty_next,
  output logic                     clamp_lo,
  output logic                     clamp_hi
);
  localparam int SUM_W = ((SCL_W > CMP_W + 1) ? SCL_W : CMP_W + 1) + 1;
  localparam logic signed [SUM_W-1:0] PER_S = SUM_W'(PERIOD);

  function automatic logic signed [SUM_W-1:0] accumulate(
    input logic [CMP_W-1:0] d, input logic signed [SCL_W-1:0] e);
    return SUM_W'(signed'({1'b0, d})) + SUM_W'(e);
  endfunction

  logic signed [SUM_W-1:0] sum_raw;
  assign sum_raw  = accumulate(duty_old, err_scaled);
  assign clamp_lo = (sum_raw <= 0);
  assign clamp_hi = (sum_raw >= PER_S);

  always_comb begin
    if (clamp_lo)      duty_next = '0;
    else if (clamp_hi) duty_next = CMP_W'(PERIOD);
    else               duty_next = sum_raw[CMP_W-1:0];
  end
endmodule

// File: rtl/cur_duty_reg.sv
module cur_duty_reg
  import cur_reg_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int REF_W    = 12,
  parameter int PERIOD   = 500,
  parameter int CMP_W    = $clog2(PERIOD + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic [SAMPLE_W-1:0]      smp_code,
  input  logic signed [REF_W-1:0]  iref,
  input  logic signed [2:0]        gain_exp,
  output logic [CMP_W-1:0]         duty_cmp
);
  localparam int ERR_W = ((SAMPLE_W + 1) > REF_W ? (SAMPLE_W + 1) : REF_W) + 1;
  localparam int SCL_W = ERR_W + GAIN_MAX_LSH;

  logic signed [SCL_W-1:0] err_scaled;
  logic [CMP_W-1:0]        duty_next;
  logic                    clamp_lo;
  logic                    clamp_hi;
  logic [CMP_W-1:0]        duty_q;

  cur_err_scale #(.SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .SCL_W(SCL_W)) u_err (
    .smp_code   (smp_code),
    .iref       (iref),
    .gain_exp   (gain_t'(gain_exp)),
    .err_scaled (err_scaled)
  );

  cur_duty_clamp #(.PERIOD(PERIOD), .CMP_W(CMP_W), .SCL_W(SCL_W)) u_clamp (
    .duty_old   (duty_q),
    .err_scaled (err_scaled),
    .duty_next  (duty_next),
    .clamp_lo   (clamp_lo),
    .clamp_hi   (clamp_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= CMP_W'(PERIOD);
    else if (smp_vld) duty_q <= duty_next;
  end

  assign duty_cmp = duty_q;
endmodule

// File: rtl/cur_duty_reg_chk.sv
module cur_duty_reg_chk #(
  parameter int PERIOD = 500,
  parameter int CMP_W  = 9,
  parameter int SCL_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic [CMP_W-1:0]        duty_cmp,
  input logic signed [SCL_W-1:0] err_scaled,
  input logic                    clamp_lo,
  input logic                    clamp_hi
);
  a_r1_reset_value: assert property (@(posedge clk)
    !rst_n |=> (duty_cmp == CMP_W'(PERIOD)));

  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    duty_cmp <= CMP_W'(PERIOD));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(duty_cmp));

  a_r4_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && clamp_lo) |=> (duty_cmp == '0));

  a_r5_ceil_period: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && clamp_hi) |=> (duty_cmp == CMP_W'(PERIOD)));

  a_r3_rises_on_excess: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (err_scaled > 0) && !clamp_hi) |=> (duty_cmp > $past(duty_cmp)));
endmodule

bind cur_duty_reg cur_duty_reg_chk #(.PERIOD(PERIOD), .CMP_W(CMP_W), .SCL_W(SCL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_vld    (smp_vld),
  .duty_cmp   (duty_cmp),
  .err_scaled (err_scaled),
  .clamp_lo   (clamp_lo),
  .clamp_hi   (clamp_hi)
);

// File: tb/sim_cur_duty_reg.sv
`timescale 1ns/1ps
module sim_cur_duty_reg;
  localparam int PER = 500;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_vld = 1'b0;
  logic [9:0]        smp_code = '0;
  logic signed [11:0] iref = '0;
  logic signed [2:0] gain_exp = '0;
  logic [8:0]        duty_cmp;

  int checks = 0;
  int errors = 0;
  int model = PER;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cur_duty_reg u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .iref(iref), .gain_exp(gain_exp), .duty_cmp(duty_cmp)
  );

  function automatic int next_duty(int d, int s, int r, int g);
    int e, st, sum;
    e = s - r;
    if (g >= 0) st = e * (1 << g);
    else        st = e >>> (-g);
    sum = d + st;
    if (sum <= 0)   return 0;
    if (sum >= PER) return PER;
    return sum;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s duty_cmp=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // called at a falling edge; applies inputs, waits one rising edge, checks at next falling edge
  task automatic step(string tag, int s, int r, int g, bit v);
    smp_code = 10'(s);
    iref     = 12'(r);
    gain_exp = 3'(g);
    smp_vld  = v;
    @(posedge clk);
    @(negedge clk);
    if (v) model = next_duty(model, s, r, g);
    check(tag, int'(duty_cmp), model);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", int'(duty_cmp), PER);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(duty_cmp), PER);

    // R8/R6: idle changes do not move the compare
    step("R8 idle", 1000, -500, 3, 1'b0);
    step("R6 idle hold", 0, 2000, 3, 1'b0);

    // R2 sign: measured above reference raises the compare (already at top: R5)
    step("R5 saturate high", 400, 100, 0, 1'b1);
    // measured below reference lowers it
    step("R2 lower", 100, 300, 0, 1'b1);        // 500-200 = 300
    step("R2 raise", 150, 100, 0, 1'b1);        // 350
    // exact bounds
    step("R4 exact zero", 0, 350, 0, 1'b1);     // 0
    step("R4 below zero", 0, 5, 0, 1'b1);       // stays 0
    step("R5 exact period", 500, 0, 0, 1'b1);   // 500
    step("R2 mid", 10, 11, 0, 1'b1);            // 499
    step("R5 just over", 2, 0, 0, 1'b1);        // 500
    // R3 floor of negative right shift
    step("R3 floor neg", 0, 3, -1, 1'b1);       // -3>>>1 = -2 -> 498
    step("R3 floor pos", 3, 0, -2, 1'b1);       // 0 -> 498
    step("R3 shift left", 0, 10, 2, 1'b1);      // -40 -> 458
    // R7 extremes
    step("R7 max positive", 1023, -2048, 3, 1'b1);
    step("R7 max negative", 0, 2047, 3, 1'b1);
    step("R7 max positive again", 1023, -2048, 3, 1'b1);

    // R3 sweep over all gains and many codes/references
    for (int g = -4; g <= 3; g++) begin
      for (int s = 0; s < 1024; s += 7) begin
        int r;
        r = ((s * 13 + (g + 4) * 101) % 1400) - 200;
        step("R3 sweep", s, r, g, 1'b1);
        if ((s % 91) == 0) step("R6 sweep idle", 1023 - s, -r, -g - 1, 1'b0);
      end
    end

    // R1 mid-run reset
    step("R2 preset", 0, 200, 0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    model = PER;
    check("R1 mid-run reset", int'(duty_cmp), PER);
    rst_n = 1'b1;
    step("R6 first after reset", 100, 150, 1, 1'b1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, got=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule